// File: doc/BRIEF.md
# Receive Statistics and PHY Reset Controller

This block lives in the system clock domain next to an Ethernet receive path whose parser runs on the PHY-supplied receive clock. After a system reset it keeps the external PHY in reset, active low, for a fixed number of system cycles. It then releases the PHY and raises a ready lamp. The default of 2,000,000 cycles gives 20 ms at 100 MHz, twice the minimum reset pulse a typical 10/100 PHY needs.

Two single-bit flags arrive from the receive domain: one for an accepted frame and one for a receive error. Each passes through a chain of synchronizer flops and then a rising-edge detector. Because of the edge detector, a flag that stays high for several system cycles is still taken as one event. Accepted frames increment a counter whose low bits drive four LEDs. Each frame also starts or restarts an activity blink of fixed length. Any receive error turns on an error lamp, which stays on until the next system reset.

Top module: `frame_stats_ctrl`

## Requirements
- R1: After reset is released, `phy_rst_n` and `phy_ready` stay low for exactly RESET_CYCLES clock cycles. Both then go high together and remain high until the next reset.
- R2: While reset is applied, and in the cycle after it, `frame_leds` is 0 and `activity_led`, `error_led`, `phy_rst_n` and `phy_ready` are all 0.
- R3: Each low-to-high transition of `rx_frame_pulse` increments the `frame_leds` value by exactly one. A level held high for many cycles counts only once.
- R4: `frame_leds` shows the accepted-frame count modulo 16, so the seventeenth frame after reset shows 0001.
- R5: A single frame event drives `activity_led` high for exactly BLINK_CYCLES consecutive cycles. The lamp rises in the same cycle as the LED count change.
- R6: A frame event that arrives while `activity_led` is lit restarts the full BLINK_CYCLES interval from that event.
- R7: A rising edge of `rx_error_pulse` sets `error_led`, which stays set until system reset. An error pulse leaves `frame_leds` unchanged.
- R8: `rx_frame_pulse` first sampled high at clock edge A changes `frame_leds` at edge A+2, with two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_frame_pulse | input | 1 | Frame-accepted flag from the receive clock domain (asynchronous) |
| rx_error_pulse | input | 1 | Receive-error flag from the receive clock domain (asynchronous) |
| phy_rst_n | output | 1 | Active-low reset to the PHY |
| phy_ready | output | 1 | High once the PHY reset interval has completed |
| frame_leds | output | LED_W | Low bits of the accepted-frame counter |
| activity_led | output | 1 | Stretched blink on each accepted frame |
| error_led | output | 1 | Sticky receive-error lamp |

## Verification
The assertions check several properties on every cycle:
- the ready flag stays set once set, and matches the PHY reset pin;
- each edge detector emits one-cycle events only;
- the counter steps by one on an event and holds otherwise;
- the blink lamp lights on a trigger;
- the error lamp never clears outside reset.

Only the bench scenarios can show the exact lengths and latencies. These are the reset hold length, the blink length for single and retriggered frames, the two-edge synchronizer latency, the wrap past 15 under random pulse widths and gaps, and error pulses leaving the count untouched.

// File: rtl/frame_stats_pkg.sv
package frame_stats_pkg;
  // Index of each receive-domain flag inside the crossing vector.
  localparam int CH_FRAME = 0;
  localparam int CH_ERROR = 1;
  localparam int NUM_CH   = 2;
  // Fewest flops a crossing chain may have.
  localparam int MIN_SYNC_STAGES = 2;

  typedef logic [NUM_CH-1:0] rx_flags_t;
endpackage

// File: rtl/fs_phy_reset_timer.sv
module fs_phy_reset_timer #(
  parameter int HOLD_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic phy_rst_n,
  output logic phy_ready
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] hold_cnt;
  logic          rel_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      rel_q    <= 1'b0;
      rdy_q    <= 1'b0;
    end else if (!rel_q) begin
      if (hold_cnt == LAST) begin
        rel_q <= 1'b1;
        rdy_q <= 1'b1;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  assign phy_rst_n = rel_q;
  assign phy_ready = rdy_q;

  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> rdy_q);
  assert_ready_matches_pin_R1: assert property (@(posedge clk) disable iff (rst)
    rel_q == rdy_q);
  assert_counter_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    rel_q |=> $stable(hold_cnt));
endmodule

// File: rtl/fs_pulse_sync.sv
module fs_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;

  assert_single_cycle_event_R3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/fs_stretch.sv
module fs_stretch #(
  parameter int HOLD = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic lamp
);
  localparam int SW = $clog2(HOLD + 1);

  logic [SW-1:0] left;
  logic          lamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      lamp_q <= 1'b0;
    end else if (trig) begin
      left   <= SW'(HOLD);
      lamp_q <= 1'b1;
    end else if (left != '0) begin
      left   <= left - 1'b1;
      lamp_q <= (left > SW'(1));
    end else begin
      lamp_q <= 1'b0;
    end
  end

  assign lamp = lamp_q;

  assert_lamp_on_trigger_R5: assert property (@(posedge clk) disable iff (rst)
    trig |=> lamp_q);
  assert_dark_stays_dark_R6: assert property (@(posedge clk) disable iff (rst)
    (!lamp_q && !trig) |=> !lamp_q);
endmodule

// File: rtl/frame_stats_ctrl.sv
module frame_stats_ctrl
  import frame_stats_pkg::*;
#(
  parameter int RESET_CYCLES = 2_000_000,
  parameter int BLINK_CYCLES = 5_000_000,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 16,
  parameter int LED_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_frame_pulse,
  input  logic             rx_error_pulse,
  output logic             phy_rst_n,
  output logic             phy_ready,
  output logic [LED_W-1:0] frame_leds,
  output logic             activity_led,
  output logic             error_led
);
  localparam int STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  rx_flags_t raw_flags;
  rx_flags_t evt;

  assign raw_flags[CH_FRAME] = rx_frame_pulse;
  assign raw_flags[CH_ERROR] = rx_error_pulse;

  fs_phy_reset_timer #(.HOLD_CYCLES(RESET_CYCLES)) u_rst_timer (
    .clk(clk), .rst(rst), .phy_rst_n(phy_rst_n), .phy_ready(phy_ready)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cross
    fs_pulse_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(raw_flags[g]), .rise(evt[g])
    );
  end

  fs_stretch #(.HOLD(BLINK_CYCLES)) u_blink (
    .clk(clk), .rst(rst), .trig(evt[CH_FRAME]), .lamp(activity_led)
  );

  logic [CNT_W-1:0] frame_cnt;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      err_q     <= 1'b0;
    end else begin
      if (evt[CH_FRAME]) frame_cnt <= frame_cnt + 1'b1;
      if (evt[CH_ERROR]) err_q     <= 1'b1;
    end
  end

  assign frame_leds = frame_cnt[LED_W-1:0];
  assign error_led  = err_q;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    evt[CH_FRAME] |=> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1));
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !evt[CH_FRAME] |=> $stable(frame_cnt));
  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: tb/tb_frame_stats_ctrl.sv
module tb_frame_stats_ctrl;
  localparam int RST_N = 40;
  localparam int BLINK = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm = 1'b0;
  logic err = 1'b0;
  logic phy_rst_n, phy_ready, activity_led, error_led;
  logic [3:0] frame_leds;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_n  = 0;

  always #2.5 clk = ~clk;

  frame_stats_ctrl #(.RESET_CYCLES(RST_N), .BLINK_CYCLES(BLINK)) dut (
    .clk(clk), .rst(rst), .rx_frame_pulse(frm), .rx_error_pulse(err),
    .phy_rst_n(phy_rst_n), .phy_ready(phy_ready), .frame_leds(frame_leds),
    .activity_led(activity_led), .error_led(error_led)
  );

  function automatic int exp_leds(int n);
    return n % 16;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input int hi, input int lo);
    frm = 1'b1;
    repeat (hi) step();
    frm = 1'b0;
    repeat (lo) step();
    exp_n++;
  endtask

  task automatic wait_dark();
    while (activity_led) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int lit;
    void'($urandom(32'd4711));
    @(negedge clk);
    repeat (3) step();
    // R2: state held in reset
    chk("R2 leds", int'(frame_leds), 0);
    chk("R2 activity", int'(activity_led), 0);
    chk("R2 error", int'(error_led), 0);
    chk("R2 phy_rst_n", int'(phy_rst_n), 0);
    chk("R2 phy_ready", int'(phy_ready), 0);

    // R1: reset hold length
    rst = 1'b0;
    n = 0;
    while (!phy_rst_n && n < 1000) begin
      step();
      n++;
    end
    chk("R1 hold cycles", n, RST_N);
    chk("R1 ready", int'(phy_ready), 1);

    // R8 latency and R3 long level counts once
    frm = 1'b1;
    step();
    chk("R8 after edge A", int'(frame_leds), 0);
    step();
    chk("R8 after edge A+1", int'(frame_leds), 0);
    step();
    exp_n = 1;
    chk("R8 after edge A+2", int'(frame_leds), 1);
    chk("R5 lamp rises with count", int'(activity_led), 1);
    repeat (12) step();
    chk("R3 long level counted once", int'(frame_leds), 1);
    frm = 1'b0;
    repeat (4) step();
    wait_dark();

    // R5: single blink length
    frm = 1'b1;
    repeat (3) step();
    exp_n++;
    lit = int'(activity_led);
    frm = 1'b0;
    while (activity_led && lit < 1000) begin
      step();
      if (activity_led) lit++;
    end
    chk("R5 blink length", lit, BLINK);

    // R6: retrigger restarts interval
    frm = 1'b1;
    repeat (3) step();
    exp_n++;
    frm = 1'b0;
    lit = int'(activity_led);
    for (int i = 1; i < 1000; i++) begin
      if (i == 8) frm = 1'b1;
      if (i == 11) frm = 1'b0;
      step();
      if (!activity_led) break;
      lit++;
    end
    exp_n++;
    chk("R6 retriggered length", lit, 10 + BLINK);
    chk("R3 two frames counted", int'(frame_leds), exp_leds(exp_n));

    // R3/R4: random widths and gaps, past the wrap
    for (int k = 0; k < 24; k++) begin
      int prev;
      prev = exp_leds(exp_n);
      send_frame(2 + int'($urandom % 5), 4 + int'($urandom % 6));
      if (exp_leds(exp_n) < prev)
        chk("R4 wrap", int'(frame_leds), exp_leds(exp_n));
      else
        chk("R3 random frame", int'(frame_leds), exp_leds(exp_n));
    end
    chk("R7 no error yet", int'(error_led), 0);

    // R7: sticky error, count untouched
    err = 1'b1;
    repeat (3) step();
    err = 1'b0;
    repeat (3) step();
    chk("R7 error set", int'(error_led), 1);
    chk("R7 count unchanged", int'(frame_leds), exp_leds(exp_n));
    repeat (50) step();
    err = 1'b1;
    step();
    err = 1'b0;
    repeat (20) step();
    chk("R7 error still set", int'(error_led), 1);

    // R2/R1: reset clears everything again
    rst = 1'b1;
    repeat (2) step();
    chk("R2 leds after reset", int'(frame_leds), 0);
    chk("R2 error after reset", int'(error_led), 0);
    chk("R1 phy reset reasserted", int'(phy_rst_n), 0);
    rst = 1'b0;
    step();
    chk("R2 ready low after reset", int'(phy_ready), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule